// File: doc/BRIEF.md
# System Global Control Register File

This block holds the chip's global configuration and status words: 32-bit registers in a 4 KiB window, reached over a simple request/response register bus. Each register has a fixed access policy: plain read/write, read-only, write-one-to-clear or write-one-to-set. The policy is chosen by the register's word index, which is the byte offset divided by four.

At reset every register loads a constant default. Two registers take their value from strap input ports instead. A third one, interrupt control 3, combines a constant with a memory-size code that is worked out at elaboration from the `DRAM_MB` parameter. The upper scratchpad and semaphore region at 0xE00 and above also accepts paired 64-bit accesses. Any request the block cannot carry out returns an error response and changes no state.

A requester raises `req_valid_i` with an address, a write flag, a width flag and write data. The block is always ready. Exactly one cycle later it answers with `rsp_valid_o`, read data and an error bit.

Top module: `gcr_regfile`

## Requirements
- R1: The word index is `req_addr_i[11:2]`. A 32-bit read returns the word in `rsp_rdata_o[31:0]` with `[63:32]` zero. A 32-bit write to a read/write register replaces the word, for example at offset 0x0C0.
- R2: A read at a word index of 992 or more (offset 0xF80 and up) returns zero without error. A write there is dropped and `rsp_err_o` is 1.
- R3: Offsets 0x000 (part id), 0x004 (strap copy) and 0x03C (interrupt status) are read-only. A write leaves them unchanged and gives `rsp_err_o`=1.
- R4: Offsets 0x06C (reset cause) and 0x0D4 (coprocessor status) are write-one-to-clear. Each written 1 clears that bit and each written 0 keeps it. A bit never rises by itself.
- R5: Offsets 0x070 (reset lock) and 0x07C (module disable) are write-one-to-set. A write ORs into the stored value, so a set bit never falls.
- R6: A 64-bit access (`req_wide_i`=1) is accepted only for 0xE00 <= offset < 0xF7C with `req_addr_i[2]`=0. Bits [31:0] go to the addressed word and bits [63:32] to the next word. Any other 64-bit access gives an error, read data zero and no state change.
- R7: An access with `req_addr_i[1:0]` not equal to 0 is rejected with an error and changes nothing.
- R8: Reset defaults: 0x000 = `PART_ID`, 0x014 = 0x0000_FFFF, 0x060 = 0x0008_0000, 0x06C = 0x8000_0000, each of 0xF00..0xF7C = 1, and every other register 0.
- R9: During reset, 0x004 loads from `strap_pwron_i` and 0x07C loads from `strap_mdis_i`.
- R10: 0x09C resets to 0x0000_1002 | (log2(`DRAM_MB`/128) << 8). A `DRAM_MB` that is not a power of two between 128 and 2048 fails an elaboration check.
- R11: `req_ready_o` is always 1. Every request gets `rsp_valid_o` one cycle later, and there is no response in a cycle that follows no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Always 1 |
| req_addr_i | input | 12 | Byte offset in the window |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wide_i | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_wdata_i | input | 64 | Write data; bits [63:32] are used only for 64-bit writes |
| rsp_valid_o | output | 1 | Response present, one cycle after the request |
| rsp_rdata_o | output | 64 | Read data |
| rsp_err_o | output | 1 | Request rejected |
| strap_pwron_i | input | 32 | Reset value for offset 0x004 |
| strap_mdis_i | input | 32 | Reset value for offset 0x07C |

## Verification
The bench first reads the reset image: constants, strap copies and the memory-size code. This tells a wrong default apart from a wrong overlay source. Writes of all-ones and of mixed patterns then go to one register of each policy, and each is read back. The results separate replace, clear-on-one, set-on-one and ignore behaviour, which a single all-ones pattern could confuse. 64-bit accesses are tried at the region base, at its last legal pair, at an odd word and below the region. Follow-up 32-bit reads check both halves and show that rejected accesses left state alone. Out-of-range and misaligned requests check the split between a silent zero read and an error.

// File: rtl/gcr_pkg.sv
package gcr_pkg;
  typedef enum logic [1:0] {POL_RW, POL_RO, POL_W1C, POL_W1S} pol_e;

  localparam int IDX_PART    = 0;
  localparam int IDX_STRAP   = 1;
  localparam int IDX_PULL    = 5;
  localparam int IDX_IRQSTAT = 15;
  localparam int IDX_IC2     = 24;
  localparam int IDX_RSTCAU  = 27;
  localparam int IDX_RLOCK   = 28;
  localparam int IDX_MDIS    = 31;
  localparam int IDX_IC3     = 39;
  localparam int IDX_CPST    = 53;
  localparam int SEM_BASE    = 960;
  localparam int SEM_N       = 32;

  function automatic pol_e pol_of(input int idx);
    case (idx)
      IDX_PART, IDX_STRAP, IDX_IRQSTAT: return POL_RO;
      IDX_RSTCAU, IDX_CPST:             return POL_W1C;
      IDX_RLOCK, IDX_MDIS:              return POL_W1S;
      default:                          return POL_RW;
    endcase
  endfunction

  function automatic logic [31:0] reset_const(input int idx, input logic [31:0] part,
                                              input logic [2:0] code);
    case (idx)
      IDX_PART:   return part;
      IDX_PULL:   return 32'h0000_FFFF;
      IDX_IC2:    return 32'h0008_0000;
      IDX_RSTCAU: return 32'h8000_0000;
      IDX_IC3:    return 32'h0000_1002 | ({29'd0, code} << 8);
      default:    return (idx >= SEM_BASE && idx < SEM_BASE + SEM_N) ? 32'd1 : 32'd0;
    endcase
  endfunction
endpackage

// File: rtl/gcr_decode.sv
module gcr_decode
  import gcr_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NR_WORDS  = 992,
  parameter int WIDE_BASE = 'hE00,
  localparam int IDX_W    = ADDR_W - 2
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              wide_i,
  output logic [IDX_W-1:0]  word_o,
  output logic              in_range_o,
  output logic              err_o,
  output logic              wr_o,
  output logic              rd_o
);
  localparam int WIDE_LIMIT = (NR_WORDS - 1) * 4;

  logic misal, wide_ok, ro;

  always_comb begin
    word_o     = addr_i[ADDR_W-1:2];
    in_range_o = int'(word_o) < NR_WORDS;
    misal      = (addr_i[1:0] != 2'b00) || (wide_i && addr_i[2]);
    wide_ok    = int'(addr_i) >= WIDE_BASE && int'(addr_i) < WIDE_LIMIT;
    ro         = in_range_o && (pol_of(int'(word_o)) == POL_RO);
    err_o      = misal || (wide_i && !wide_ok) || (we_i && !in_range_o) || (we_i && ro);
    wr_o       = valid_i && we_i && !err_o && in_range_o;
    rd_o       = valid_i && !we_i && !err_o && in_range_o;
  end
endmodule

// File: rtl/gcr_word.sv
module gcr_word
  import gcr_pkg::*;
#(
  parameter pol_e POLICY = POL_RW,
  parameter int   DW     = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] rst_val_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= rst_val_i;
    end else if (we_i) begin
      case (POLICY)
        POL_RW:  q_o <= wdata_i;
        POL_W1C: q_o <= q_o & ~wdata_i;
        POL_W1S: q_o <= q_o | wdata_i;
        default: q_o <= q_o;
      endcase
    end
  end
endmodule

// File: rtl/gcr_regfile.sv
module gcr_regfile
  import gcr_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          NR_WORDS  = 992,
  parameter int          WIDE_BASE = 'hE00,
  parameter int          DRAM_MB   = 512,
  parameter logic [31:0] PART_ID   = 32'h0A17_0001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_we_i,
  input  logic              req_wide_i,
  input  logic [63:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic [63:0]       rsp_rdata_o,
  output logic              rsp_err_o,
  input  logic [31:0]       strap_pwron_i,
  input  logic [31:0]       strap_mdis_i
);
  localparam int         IDX_W     = ADDR_W - 2;
  localparam logic [2:0] SIZE_CODE = 3'($clog2(DRAM_MB / 128));

  initial begin : p_dram_size_r10
    assert (DRAM_MB >= 128 && DRAM_MB <= 2048 && (DRAM_MB & (DRAM_MB - 1)) == 0)
      else $error("DRAM_MB must be a power of two in 128..2048");
  end

  logic [IDX_W-1:0] word, word_lo, word_hi;
  logic             in_range, err, wr, rd;
  logic [31:0]      q [NR_WORDS];

  assign req_ready_o = 1'b1;

  gcr_decode #(
    .ADDR_W(ADDR_W), .NR_WORDS(NR_WORDS), .WIDE_BASE(WIDE_BASE)
  ) u_dec (
    .valid_i(req_valid_i), .addr_i(req_addr_i), .we_i(req_we_i), .wide_i(req_wide_i),
    .word_o(word), .in_range_o(in_range), .err_o(err), .wr_o(wr), .rd_o(rd)
  );

  assign word_lo = in_range ? word : '0;
  assign word_hi = (in_range && req_wide_i) ? word + 1'b1 : '0;

  for (genvar k = 0; k < NR_WORDS; k++) begin : g_word
    logic [31:0] rv, wd;
    logic        we;
    if (k == IDX_STRAP) begin : g_rs
      assign rv = strap_pwron_i;
    end else if (k == IDX_MDIS) begin : g_rm
      assign rv = strap_mdis_i;
    end else begin : g_rc
      assign rv = reset_const(k, PART_ID, SIZE_CODE);
    end
    always_comb begin
      we = 1'b0;
      wd = req_wdata_i[31:0];
      if (wr && int'(word) == k) begin
        we = 1'b1;
      end else if (wr && req_wide_i && int'(word) + 1 == k) begin
        we = 1'b1;
        wd = req_wdata_i[63:32];
      end
    end
    gcr_word #(.POLICY(pol_of(k)), .DW(32)) u_w (
      .clk_i(clk_i), .rst_ni(rst_ni), .rst_val_i(rv),
      .we_i(we), .wdata_i(wd), .q_o(q[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_err_o   <= req_valid_i && err;
      rsp_rdata_o <= '0;
      if (rd) rsp_rdata_o <= {req_wide_i ? q[word_hi] : 32'd0, q[word_lo]};
    end
  end

  p_one_cycle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  p_no_spurious_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  p_ro_err_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_we_i && !req_wide_i && req_addr_i[1:0] == 2'b00 &&
     (req_addr_i[ADDR_W-1:2] == IDX_W'(IDX_PART) || req_addr_i[ADDR_W-1:2] == IDX_W'(IDX_STRAP) ||
      req_addr_i[ADDR_W-1:2] == IDX_W'(IDX_IRQSTAT))) |=> rsp_err_o);
  p_w1c_no_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((q[IDX_RSTCAU] & ~$past(q[IDX_RSTCAU])) == 32'd0));
  p_w1s_no_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((q[IDX_MDIS] & $past(q[IDX_MDIS])) == $past(q[IDX_MDIS])));
  p_wide_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_wide_i && int'(req_addr_i) < WIDE_BASE) |=> (rsp_err_o && rsp_rdata_o == 64'd0));
  p_misalign_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_addr_i[1:0] != 2'b00) |=> rsp_err_o);
  p_oor_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_we_i && !req_wide_i && req_addr_i[1:0] == 2'b00 &&
     int'(req_addr_i[ADDR_W-1:2]) >= NR_WORDS) |=> (!rsp_err_o && rsp_rdata_o == 64'd0));
endmodule

// File: tb/sim_gcr_regfile.sv
module sim_gcr_regfile;
  localparam logic [31:0] PART  = 32'h0A17_0001;
  localparam logic [31:0] SPW   = 32'h1234_5678;
  localparam logic [31:0] SMD   = 32'h0000_00A5;
  localparam int          NRW   = 992;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, req_we = 0, req_wide = 0;
  logic [11:0] req_addr = '0;
  logic [63:0] req_wdata = '0, rsp_rdata;
  logic rsp_valid, rsp_err;
  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] m [NRW];

  always #4 clk = ~clk;

  gcr_regfile #(.DRAM_MB(512), .PART_ID(PART)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_we_i(req_we), .req_wide_i(req_wide), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err),
    .strap_pwron_i(SPW), .strap_mdis_i(SMD)
  );

  function automatic int bpol(int i);  // 0 rw, 1 ro, 2 w1c, 3 w1s
    if (i == 0 || i == 1 || i == 15) return 1;
    if (i == 27 || i == 53) return 2;
    if (i == 28 || i == 31) return 3;
    return 0;
  endfunction

  task automatic mreset();
    for (int i = 0; i < NRW; i++) m[i] = (i >= 960) ? 32'd1 : 32'd0;
    m[0] = PART; m[1] = SPW; m[31] = SMD; m[5] = 32'h0000_FFFF;
    m[24] = 32'h0008_0000; m[27] = 32'h8000_0000;
    m[39] = 32'h0000_1002 | (32'd2 << 8);
  endtask

  task automatic mwrite(int i, logic [31:0] d);
    case (bpol(i))
      0: m[i] = d;
      2: m[i] = m[i] & ~d;
      3: m[i] = m[i] | d;
      default: ;
    endcase
  endtask

  task automatic chk(string req, logic [65:0] act, logic [65:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic txn(string req, bit we, bit wide, logic [11:0] a, logic [63:0] wd);
    int w = int'(a >> 2);
    bit inr = w < NRW;
    bit rej = (a[1:0] != 0) || (wide && a[2]) || (wide && !(a >= 12'hE00 && a < 12'hF7C));
    bit eerr = 0;
    logic [63:0] erd = '0;
    if (rej) eerr = 1;
    else if (we) begin
      if (!inr || bpol(w) == 1) eerr = 1;
      else begin
        mwrite(w, wd[31:0]);
        if (wide) mwrite(w + 1, wd[63:32]);
      end
    end else if (inr) erd = {wide ? m[w + 1] : 32'd0, m[w]};
    @(negedge clk);
    req_valid = 1; req_we = we; req_wide = wide; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    chk(req, {rsp_valid, rsp_err, rsp_rdata}, {1'b1, eerr, erd});
  endtask

  task automatic rd(string req, logic [11:0] a);
    txn(req, 0, 0, a, '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    mreset();
    repeat (3) @(negedge clk);
    chk("R11 reset idle", {1'b0, 1'b0, 64'd0}, {rsp_valid, rsp_err, rsp_rdata});
    rst_n = 1;
    @(negedge clk);
    chk("R11 ready", {65'd0, req_ready}, {65'd0, 1'b1});
    chk("R11 no rsp", {65'd0, rsp_valid}, 66'd0);
    // R8 R9 R10 reset image
    rd("R8 part", 12'h000); rd("R9 strap pwron", 12'h004); rd("R9 strap mdis", 12'h07C);
    rd("R8 pull", 12'h014); rd("R8 ic2", 12'h060); rd("R8 rstcause", 12'h06C);
    rd("R10 ic3", 12'h09C); rd("R8 sem first", 12'hF00); rd("R8 sem last", 12'hF7C);
    rd("R8 plain zero", 12'h0C0); rd("R8 cpst", 12'h0D4);
    // R1 read/write
    txn("R1 write", 1, 0, 12'h0C0, 64'hDEAD_BEEF); rd("R1 readback", 12'h0C0);
    txn("R1 write2", 1, 0, 12'h0C0, 64'h0F0F_1234); rd("R1 readback2", 12'h0C0);
    // R3 read-only
    txn("R3 ro part", 1, 0, 12'h000, 64'hFFFF_FFFF); rd("R3 part kept", 12'h000);
    txn("R3 ro strap", 1, 0, 12'h004, 64'h0); rd("R3 strap kept", 12'h004);
    txn("R3 ro irq", 1, 0, 12'h03C, 64'hFFFF_FFFF); rd("R3 irq kept", 12'h03C);
    // R4 write-one-to-clear
    txn("R4 w1c zero", 1, 0, 12'h06C, 64'h0); rd("R4 kept", 12'h06C);
    txn("R4 w1c clr", 1, 0, 12'h06C, 64'h8000_0000); rd("R4 cleared", 12'h06C);
    txn("R4 w1c cp", 1, 0, 12'h0D4, 64'hFFFF_FFFF); rd("R4 cp stays", 12'h0D4);
    // R5 write-one-to-set
    txn("R5 set", 1, 0, 12'h070, 64'h0000_0102); txn("R5 zero", 1, 0, 12'h070, 64'h0);
    rd("R5 lock kept", 12'h070);
    txn("R5 mdis or", 1, 0, 12'h07C, 64'h0000_5A00); rd("R5 mdis", 12'h07C);
    // R6 wide
    txn("R6 wide wr base", 1, 1, 12'hE00, 64'h1111_2222_3333_4444);
    rd("R6 lo word", 12'hE00); rd("R6 hi word", 12'hE04);
    txn("R6 wide rd base", 0, 1, 12'hE00, '0);
    txn("R6 wide last", 1, 1, 12'hF78, 64'hAAAA_0000_0000_5555);
    txn("R6 wide rd last", 0, 1, 12'hF78, '0);
    txn("R6 wide odd", 1, 1, 12'hE04, 64'hFFFF_FFFF_FFFF_FFFF);
    txn("R6 wide odd rd", 0, 1, 12'hE04, '0);
    txn("R6 wide low", 1, 1, 12'h0C0, 64'h5555_5555_5555_5555);
    rd("R6 low kept", 12'h0C0); rd("R6 odd kept", 12'hE04);
    txn("R6 wide top", 0, 1, 12'hF7C, '0);
    // R2 out of range
    rd("R2 oor read", 12'hF80); rd("R2 oor read top", 12'hFFC);
    txn("R2 oor write", 1, 0, 12'hF80, 64'h1);
    // R7 misaligned
    txn("R7 misal wr", 1, 0, 12'h0C1, 64'h0); rd("R7 kept", 12'h0C0);
    txn("R7 misal rd", 0, 0, 12'h0C2, '0);
    @(negedge clk);
    chk("R11 idle after", {65'd0, rsp_valid}, 66'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule